// File: doc/BRIEF.md
# Interrupt Controller Reset and Disable State Keeper

This block holds the architectural register state of one processor's local interrupt controller. It decides what that state becomes in three situations: power-up reset, software disable and software re-enable. Software reaches the state through a flat word-addressed read/write port with a combinational read. An external busy input marks an interrupt receive or an IPI send that is still in flight. The block drives an enabled flag, a one-cycle pulse when a disable actually takes effect, and the register contents.

A reset loads a mixed set of values: most registers clear to zero, the destination format goes to all ones, the vector-table masks are set, and the spurious-vector register comes up with its enable bit low. A software disable is deferred while the busy input is high. Once the disable is in force, every vector-table mask is set and held set, while pending request and in-service bits are kept. Message strobes (INIT, NMI, SMI, start-up) still pass through, and writes to the command register still launch an IPI. Re-enabling lifts the hold on the masks but leaves them set until software clears them.

Prioritisation, timer counting and bus arbitration are done elsewhere. The block only stores the state those functions use and keeps it consistent.

Top module: `irq_state_keeper`

## Requirements
- R1: After reset, these word addresses read zero: task priority 0x03, logical destination 0x04, command low 0x07, command high 0x08, timer initial 0x09, timer current 0x0A, divide 0x0B, request 0x0C, in-service 0x0D, trigger mode 0x0E.
- R2: After reset, destination format (0x05) reads 0xFFFFFFFF, spurious vector (0x06) reads 0x000000FF, each vector-table entry (0x10 to 0x15) reads 0x00010000, and `enabled` is 0.
- R3: After reset, ID (0x00) and arbitration ID (0x02) both read `id_strap`. Version (0x01) reads the VERSION parameter, and a write to it changes nothing.
- R4: A write to 0x06 with bit 8 set makes `enabled` read 1 from the next cycle. A vector-table write made while the block is enabled stores all 17 bits as written, mask at bit 16.
- R5: A write to 0x06 with bit 8 clear while `busy` is low drops `enabled` at that edge and raises `disable_done` for exactly one cycle. Every vector-table entry then reads with bit 16 set and its other bits unchanged.
- R6: While the disable is in force, a vector-table write with bit 16 clear stores bits 15:0 and leaves bit 16 at 1.
- R7: A disable written while `busy` is high leaves `enabled` at 1 and the masks untouched until `busy` is sampled low. At that edge, `enabled` falls, `disable_done` pulses and the masks are set.
- R8: Writing bit 8 of 0x06 back to 1 while a disable is still pending cancels it: there is no `disable_done` pulse and `enabled` stays 1.
- R9: Re-enabling lifts the mask hold but leaves the masks at 1. A later write with bit 16 clear then clears the mask.
- R10: A pulse on `irr_set` sets request bits and records `irr_level` into the trigger-mode bits. A pulse on `irr_take` moves bits from request to in-service. A pulse on `isr_done` clears in-service bits. All of these bits are kept through a disable and can still be set while disabled.
- R11: `msg_in` (bit 0 INIT, bit 1 NMI, bit 2 SMI, bit 3 start-up) appears on `msg_out` one cycle later, whether the block is enabled or disabled.
- R12: A write to 0x07 pulses `ipi_send` for one cycle after the write edge, also while disabled.
- R13: Task priority keeps bits 7:0 and the divide register keeps bits 3:0; all other bits of these two read 0. A write to the timer initial count also loads the timer current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_strap | input | ID_W | ID loaded at reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| busy | input | 1 | Receive or IPI send in flight |
| irr_set | input | NVEC | Set request bits |
| irr_level | input | NVEC | Trigger mode for bits being set (1 = level) |
| irr_take | input | NVEC | Move request bits to in-service |
| isr_done | input | NVEC | Clear in-service bits |
| msg_in | input | 4 | INIT, NMI, SMI, start-up message strobes |
| msg_out | output | 4 | Forwarded message strobes |
| ipi_send | output | 1 | IPI launch pulse |
| enabled | output | 1 | Effective enable state |
| disable_done | output | 1 | Pulse when a disable takes effect |

## Verification
The hardest case to reach is a disable that waits on `busy`. In that case the enable bit the register holds and the `enabled` output disagree for several cycles, and a re-enable can cancel the pending disable. The stimulus holds `busy` high across the disable write, reads a vector-table entry to show its mask untouched, and then releases `busy` at a known negedge so that the fall edge and the `disable_done` pulse can be placed exactly. A second pass writes bit 8 back to 1 before `busy` falls and checks that no pulse follows.

// File: rtl/irqk_pkg.sv
package irqk_pkg;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int MSG_W = 4;
  localparam int LVT_W = 17;
  localparam int LVT_MASK_BIT = 16;
  localparam int SVR_EN_BIT = 8;

  localparam logic [AW-1:0] A_ID    = 5'h00;
  localparam logic [AW-1:0] A_VER   = 5'h01;
  localparam logic [AW-1:0] A_ARB   = 5'h02;
  localparam logic [AW-1:0] A_TPR   = 5'h03;
  localparam logic [AW-1:0] A_LDR   = 5'h04;
  localparam logic [AW-1:0] A_DFR   = 5'h05;
  localparam logic [AW-1:0] A_SVR   = 5'h06;
  localparam logic [AW-1:0] A_ICRL  = 5'h07;
  localparam logic [AW-1:0] A_ICRH  = 5'h08;
  localparam logic [AW-1:0] A_TINIT = 5'h09;
  localparam logic [AW-1:0] A_TCUR  = 5'h0A;
  localparam logic [AW-1:0] A_DIV   = 5'h0B;
  localparam logic [AW-1:0] A_IRR   = 5'h0C;
  localparam logic [AW-1:0] A_ISR   = 5'h0D;
  localparam logic [AW-1:0] A_TMR   = 5'h0E;
  localparam int LVT_BASE = 16;

  localparam logic [DW-1:0]    DFR_RST = '1;
  localparam logic [DW-1:0]    SVR_RST = 32'h0000_00FF;
  localparam logic [LVT_W-1:0] LVT_RST = 17'h1_0000;

  // Vector-table write merge: under the hold a mask bit can be set, never cleared.
  function automatic logic [LVT_W-1:0] lvt_merge(input logic [LVT_W-1:0] old_v,
                                                 input logic [LVT_W-1:0] new_v,
                                                 input logic hold);
    logic [LVT_W-1:0] r;
    r = new_v;
    if (hold) r[LVT_MASK_BIT] = old_v[LVT_MASK_BIT] | new_v[LVT_MASK_BIT];
    return r;
  endfunction

  // Trigger-mode update: bits being set take their level flag, others keep.
  function automatic logic [DW-1:0] tmr_next(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] set,
                                             input logic [DW-1:0] lvl);
    return (cur & ~set) | (set & lvl);
  endfunction
endpackage

// File: rtl/irqk_enable_ctl.sv
module irqk_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic svr_wr,
  input  logic svr_en_bit,
  input  logic busy,
  output logic enabled,
  output logic force_masks,
  output logic dis_fire,
  output logic disable_done
);
  logic en_q, pend_q, force_q, done_q;
  logic want_on, want_off;

  assign want_on  = svr_wr &&  svr_en_bit;
  assign want_off = svr_wr && !svr_en_bit;
  // A disable lands only on an edge where no transfer is in flight.
  assign dis_fire = !busy && !want_on && (want_off || pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      force_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= dis_fire;
      if (want_on) begin
        en_q    <= 1'b1;
        pend_q  <= 1'b0;
        force_q <= 1'b0;
      end else if (dis_fire) begin
        en_q    <= 1'b0;
        pend_q  <= 1'b0;
        force_q <= 1'b1;
      end else if (want_off) begin
        pend_q  <= 1'b1;
      end
    end
  end

  assign enabled      = en_q;
  assign force_masks  = force_q;
  assign disable_done = done_q;

  assert_done_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !en_q);
  assert_fall_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> !$past(busy));
  assert_hold_only_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |-> !en_q);
endmodule

// File: rtl/irqk_lvt_bank.sv
module irqk_lvt_bank
  import irqk_pkg::*;
#(
  parameter int N_LVT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [LVT_W-1:0] wdata,
  input  logic             force_masks,
  input  logic             set_all,
  output logic [LVT_W-1:0] entry [N_LVT]
);
  logic [N_LVT-1:0] mask_vec;

  for (genvar i = 0; i < N_LVT; i++) begin : g_ent
    logic hit;
    assign hit = wr_en && (addr == AW'(LVT_BASE + i));
    always_ff @(posedge clk) begin
      if (!rst_n) entry[i] <= LVT_RST;
      else if (set_all) entry[i][LVT_MASK_BIT] <= 1'b1;
      else if (hit) entry[i] <= lvt_merge(entry[i], wdata, force_masks);
    end
    assign mask_vec[i] = entry[i][LVT_MASK_BIT];
  end

  assert_masks_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_masks |-> (&mask_vec));
endmodule

// File: rtl/irqk_pending.sv
module irqk_pending
  import irqk_pkg::*;
#(
  parameter int NVEC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] irr_set,
  input  logic [NVEC-1:0] irr_level,
  input  logic [NVEC-1:0] irr_take,
  input  logic [NVEC-1:0] isr_done,
  output logic [NVEC-1:0] irr,
  output logic [NVEC-1:0] isr,
  output logic [NVEC-1:0] tmr
);
  logic [DW-1:0] tmr_w;
  assign tmr_w = tmr_next(DW'(tmr), DW'(irr_set), DW'(irr_level));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
    end else begin
      irr <= (irr | irr_set) & ~irr_take;
      isr <= (isr | (irr_take & irr)) & ~isr_done;
      tmr <= tmr_w[NVEC-1:0];
    end
  end

  assert_irr_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|irr_set) && !(|irr_take)) |=> (irr == $past(irr)));
endmodule

// File: rtl/irqk_msg_relay.sv
module irqk_msg_relay
  import irqk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MSG_W-1:0] msg_in,
  input  logic             icr_wr,
  output logic [MSG_W-1:0] msg_out,
  output logic             ipi_send
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_out  <= '0;
      ipi_send <= 1'b0;
    end else begin
      msg_out  <= msg_in;
      ipi_send <= icr_wr;
    end
  end
endmodule

// File: rtl/irq_state_keeper.sv
module irq_state_keeper
  import irqk_pkg::*;
#(
  parameter int          ID_W    = 4,
  parameter int          NVEC    = 32,
  parameter int          N_LVT   = 6,
  parameter logic [31:0] VERSION = 32'h0005_0014
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  id_strap,
  input  logic             wr_en,
  input  logic [4:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             busy,
  input  logic [NVEC-1:0]  irr_set,
  input  logic [NVEC-1:0]  irr_level,
  input  logic [NVEC-1:0]  irr_take,
  input  logic [NVEC-1:0]  isr_done,
  input  logic [3:0]       msg_in,
  output logic [3:0]       msg_out,
  output logic             ipi_send,
  output logic             enabled,
  output logic             disable_done
);
  localparam int TPR_W = 8;
  localparam int DIV_W = 4;

  logic [ID_W-1:0]  id_q, arb_q;
  logic [TPR_W-1:0] tpr_q;
  logic [DIV_W-1:0] div_q;
  logic [DW-1:0]    ldr_q, dfr_q, svr_q, icrl_q, icrh_q, tinit_q, tcur_q;
  logic [NVEC-1:0]  irr_q, isr_q, tmr_q;
  logic [LVT_W-1:0] lvt_q [N_LVT];

  logic svr_wr, icr_wr;
  logic force_masks, dis_fire;

  assign svr_wr = wr_en && (addr == A_SVR);
  assign icr_wr = wr_en && (addr == A_ICRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q    <= id_strap;
      arb_q   <= id_strap;
      tpr_q   <= '0;
      div_q   <= '0;
      ldr_q   <= '0;
      dfr_q   <= DFR_RST;
      svr_q   <= SVR_RST;
      icrl_q  <= '0;
      icrh_q  <= '0;
      tinit_q <= '0;
      tcur_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_ID:    id_q    <= wdata[ID_W-1:0];
        A_TPR:   tpr_q   <= wdata[TPR_W-1:0];
        A_LDR:   ldr_q   <= wdata;
        A_DFR:   dfr_q   <= wdata;
        A_SVR:   svr_q   <= wdata;
        A_ICRL:  icrl_q  <= wdata;
        A_ICRH:  icrh_q  <= wdata;
        A_TINIT: begin
          tinit_q <= wdata;
          tcur_q  <= wdata;
        end
        A_DIV:   div_q   <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  irqk_enable_ctl u_en (
    .clk(clk), .rst_n(rst_n), .svr_wr(svr_wr), .svr_en_bit(wdata[SVR_EN_BIT]),
    .busy(busy), .enabled(enabled), .force_masks(force_masks), .dis_fire(dis_fire),
    .disable_done(disable_done)
  );

  irqk_lvt_bank #(.N_LVT(N_LVT)) u_lvt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata[LVT_W-1:0]),
    .force_masks(force_masks), .set_all(dis_fire), .entry(lvt_q)
  );

  irqk_pending #(.NVEC(NVEC)) u_pend (
    .clk(clk), .rst_n(rst_n), .irr_set(irr_set), .irr_level(irr_level),
    .irr_take(irr_take), .isr_done(isr_done), .irr(irr_q), .isr(isr_q), .tmr(tmr_q)
  );

  irqk_msg_relay u_msg (
    .clk(clk), .rst_n(rst_n), .msg_in(msg_in), .icr_wr(icr_wr),
    .msg_out(msg_out), .ipi_send(ipi_send)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_ID:    rdata = DW'(id_q);
      A_VER:   rdata = VERSION;
      A_ARB:   rdata = DW'(arb_q);
      A_TPR:   rdata = DW'(tpr_q);
      A_LDR:   rdata = ldr_q;
      A_DFR:   rdata = dfr_q;
      A_SVR:   rdata = svr_q;
      A_ICRL:  rdata = icrl_q;
      A_ICRH:  rdata = icrh_q;
      A_TINIT: rdata = tinit_q;
      A_TCUR:  rdata = tcur_q;
      A_DIV:   rdata = DW'(div_q);
      A_IRR:   rdata = DW'(irr_q);
      A_ISR:   rdata = DW'(isr_q);
      A_TMR:   rdata = DW'(tmr_q);
      default: begin
        for (int i = 0; i < N_LVT; i++)
          if (addr == AW'(LVT_BASE + i)) rdata = DW'(lvt_q[i]);
      end
    endcase
  end

  assert_ipi_from_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_send |-> $past(wr_en && addr == A_ICRL));
  assert_arb_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(arb_q));
endmodule

// File: tb/irq_state_keeper_tb_top.sv
module irq_state_keeper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;
  localparam logic [31:0] VER = 32'h0005_0014;
  localparam logic [3:0]  STRAP = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy = 1'b0;
  logic [NV-1:0] irr_set = '0, irr_level = '0, irr_take = '0, isr_done = '0;
  logic [3:0]  msg_in = '0;
  logic [3:0]  msg_out;
  logic        ipi_send, enabled, disable_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_state_keeper dut_i (
    .clk(clk), .rst_n(rst_n), .id_strap(STRAP), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .irr_set(irr_set),
    .irr_level(irr_level), .irr_take(irr_take), .isr_done(isr_done),
    .msg_in(msg_in), .msg_out(msg_out), .ipi_send(ipi_send),
    .enabled(enabled), .disable_done(disable_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 tpr", 5'h03, 0);   rd_chk("R1 ldr", 5'h04, 0);
    rd_chk("R1 icrl", 5'h07, 0);  rd_chk("R1 icrh", 5'h08, 0);
    rd_chk("R1 tinit", 5'h09, 0); rd_chk("R1 tcur", 5'h0A, 0);
    rd_chk("R1 div", 5'h0B, 0);   rd_chk("R1 irr", 5'h0C, 0);
    rd_chk("R1 isr", 5'h0D, 0);   rd_chk("R1 tmr", 5'h0E, 0);
    rd_chk("R2 dfr", 5'h05, 32'hFFFF_FFFF);
    rd_chk("R2 svr", 5'h06, 32'h0000_00FF);
    for (int i = 0; i < 6; i++) rd_chk("R2 lvt", 5'(16 + i), 32'h0001_0000);
    chk("R2 enabled", 32'(enabled), 0);
    rd_chk("R3 id", 5'h00, 32'(STRAP));
    rd_chk("R3 arb", 5'h02, 32'(STRAP));
    rd_chk("R3 ver", 5'h01, VER);
    wr(5'h01, 32'h1234_5678);
    rd_chk("R3 ver after write", 5'h01, VER);
  endtask

  task automatic t_regs;
    wr(5'h03, 32'h0000_1234); rd_chk("R13 tpr", 5'h03, 32'h34);
    wr(5'h0B, 32'hFFFF_FFFF); rd_chk("R13 div", 5'h0B, 32'hF);
    wr(5'h09, 32'h0000_0055); rd_chk("R13 tcur", 5'h0A, 32'h55);
  endtask

  task automatic t_pending;
    @(negedge clk); irr_set = 32'h0000_0F00; irr_level = 32'h0000_0300;
    @(negedge clk); irr_set = '0; irr_level = '0; irr_take = 32'h0000_0100;
    @(negedge clk); irr_take = '0;
    rd_chk("R10 irr", 5'h0C, 32'h0000_0E00);
    rd_chk("R10 isr", 5'h0D, 32'h0000_0100);
    rd_chk("R10 tmr", 5'h0E, 32'h0000_0300);
  endtask

  task automatic t_enable;
    wr(5'h06, 32'h0000_01FF);
    chk("R4 enabled", 32'(enabled), 1);
    wr(5'h12, 32'h0000_0042);
    rd_chk("R4 lvt unmasked", 5'h12, 32'h42);
  endtask

  task automatic t_disable_idle;
    wr(5'h06, 32'h0000_00FF);
    chk("R5 enabled low", 32'(enabled), 0);
    chk("R5 done pulse", 32'(disable_done), 1);
    @(negedge clk);
    chk("R5 done one cycle", 32'(disable_done), 0);
    rd_chk("R5 lvt2 masked", 5'h12, 32'h0001_0042);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d;
      rd(5'(16 + i), d);
      chk("R5 mask set", 32'(d[16]), 1);
    end
    wr(5'h12, 32'h0000_0077);
    rd_chk("R6 mask held", 5'h12, 32'h0001_0077);
    rd_chk("R10 irr kept", 5'h0C, 32'h0000_0E00);
    rd_chk("R10 isr kept", 5'h0D, 32'h0000_0100);
    rd_chk("R10 tmr kept", 5'h0E, 32'h0000_0300);
    @(negedge clk); irr_set = 32'h0000_0001;
    @(negedge clk); irr_set = '0;
    rd_chk("R10 set while disabled", 5'h0C, 32'h0000_0E01);
  endtask

  task automatic t_reenable;
    wr(5'h06, 32'h0000_01FF);
    chk("R9 enabled", 32'(enabled), 1);
    rd_chk("R9 mask stays", 5'h12, 32'h0001_0077);
    wr(5'h12, 32'h0000_0077);
    rd_chk("R9 mask cleared", 5'h12, 32'h0000_0077);
  endtask

  task automatic t_disable_busy;
    @(negedge clk); busy = 1'b1;
    wr(5'h06, 32'h0000_00FF);
    chk("R7 still enabled", 32'(enabled), 1);
    chk("R7 no done", 32'(disable_done), 0);
    rd_chk("R7 mask untouched", 5'h12, 32'h0000_0077);
    repeat (3) @(negedge clk);
    chk("R7 held while busy", 32'(enabled), 1);
    busy = 1'b0;
    #1 chk("R7 before edge", 32'(enabled), 1);
    @(negedge clk);
    chk("R7 enabled fell", 32'(enabled), 0);
    chk("R7 done pulse", 32'(disable_done), 1);
    rd_chk("R7 mask set", 5'h12, 32'h0001_0077);
  endtask

  task automatic t_cancel;
    int pulses;
    pulses = 0;
    wr(5'h06, 32'h0000_01FF);
    @(negedge clk); busy = 1'b1;
    wr(5'h06, 32'h0000_00FF);
    if (disable_done) pulses++;
    wr(5'h06, 32'h0000_01FF);
    if (disable_done) pulses++;
    busy = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (disable_done) pulses++;
    end
    chk("R8 no done pulse", 32'(pulses), 0);
    chk("R8 still enabled", 32'(enabled), 1);
  endtask

  task automatic t_msg_ipi;
    wr(5'h06, 32'h0000_00FF);
    chk("R11 disabled", 32'(enabled), 0);
    @(negedge clk); msg_in = 4'b0101;
    @(negedge clk); msg_in = 4'b1010;
    chk("R11 msg pass 1", 32'(msg_out), 32'h5);
    @(negedge clk); msg_in = 4'b0000;
    chk("R11 msg pass 2", 32'(msg_out), 32'hA);
    @(negedge clk);
    chk("R11 msg idle", 32'(msg_out), 0);
    wr(5'h07, 32'h0000_4030);
    chk("R12 ipi pulse", 32'(ipi_send), 1);
    @(negedge clk);
    chk("R12 ipi one cycle", 32'(ipi_send), 0);
    rd_chk("R12 icr kept", 5'h07, 32'h0000_4030);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_pending();
    t_enable();
    t_disable_idle();
    t_reenable();
    t_disable_busy();
    t_cancel();
    t_msg_ipi();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule